// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This unit evaluates one of five operations on two single-precision values, each held in a 64-bit floating-point register. The operations are equality, less-than, less-or-equal, minimum and maximum, and a 3-bit operation code selects which one runs. Before either value is used, its upper half is checked for NaN boxing. A value whose upper 32 bits are not all ones is replaced by the canonical quiet NaN.

A compare writes a plain 0 or 1 toward the integer register file. Minimum and maximum write a NaN-boxed 64-bit result back to the floating-point side. Every operation also reports an invalid-operation flag. The rules for quiet NaN, signalling NaN and signed zero follow the operation exactly.

The datapath is combinational. A parameter chooses whether the outputs come straight from it or through a single output register stage.

Top module: `fcmp_minmax_unit`

## Requirements
- R1: If bits 63:32 of an operand are not all ones, the operand is treated as the quiet NaN 0x7FC00000. That substitution alone never raises the invalid flag under op 0, 3 or 4.
- R2: Op 0 (equal) returns 1 when the operands are numerically equal, and +0 equals -0. If either operand is any NaN, it returns 0. The invalid flag rises only when an operand is a signalling NaN. A signalling NaN has exponent all ones, a nonzero fraction and fraction bit 22 clear.
- R3: Op 1 (less-than) and op 2 (less-or-equal) order non-NaN values by sign and magnitude, including infinities and denormals, and treat the two zeros as equal. If either operand is any NaN, quiet or signalling, the result is 0 and the invalid flag is set.
- R4: A compare result occupies bit 0 only. Bits 63:1 are zero.
- R5: For op 3 (min) and op 4 (max), when exactly one operand is NaN the result is the other operand. When both are NaN the result is the canonical NaN. The invalid flag rises only when an operand is a signalling NaN.
- R6: When both operands are zeros, min returns -0 if either operand is -0, and max returns +0 if either operand is +0.
- R7: Min and max return the smaller and the larger non-NaN value, with bits 63:32 of the result set to ones.
- R8: Op codes 5 to 7 produce result 0 with the invalid flag clear.
- R9: With the output register present (the default), result, invalid and valid_out appear one cycle after valid_in is sampled high. Result and invalid are zero whenever valid_out is low, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operands and op code are valid this cycle |
| op | input | 3 | Operation: 0 eq, 1 lt, 2 le, 3 min, 4 max |
| a | input | 64 | First operand, NaN-boxed single |
| b | input | 64 | Second operand, NaN-boxed single |
| result | output | 64 | Compare bit or boxed min/max value |
| invalid | output | 1 | Invalid-operation exception |
| valid_out | output | 1 | Result qualifier |

## Verification
The timing assertions assume that valid_in and op are at known values on every clock edge after reset is released. They also assume that valid_in stays low while reset is active, so each $past term refers to a cycle the bench actually drove. The bench applies every operand and op code at the falling edge, returns valid_in to low between scenarios, and holds it low throughout reset. The operand-class assertions rely on the unit's own NaN decode. The bench therefore uses only bit patterns whose class is clear-cut: quiet NaN, signalling NaN, both zeros, infinities, denormals, and values whose upper half is zero.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int REG_W  = 64;
  localparam int SP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = SP_W - EXP_W - 1;
  localparam int BOX_W  = REG_W - SP_W;
  localparam logic [SP_W-1:0] SP_CANON_NAN = 32'h7FC0_0000;

  localparam logic [2:0] OP_EQ  = 3'd0;
  localparam logic [2:0] OP_LT  = 3'd1;
  localparam logic [2:0] OP_LE  = 3'd2;
  localparam logic [2:0] OP_MIN = 3'd3;
  localparam logic [2:0] OP_MAX = 3'd4;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } sp_class_t;

  function automatic sp_class_t sp_classify(input logic [SP_W-1:0] x);
    sp_class_t c;
    logic exp_ones;
    logic frac_nz;
    exp_ones = &x[SP_W-2 -: EXP_W];
    frac_nz  = |x[FRAC_W-1:0];
    c.nan  = exp_ones && frac_nz;
    c.snan = exp_ones && frac_nz && !x[FRAC_W-1];
    c.zero = ~|x[SP_W-2:0];
    return c;
  endfunction

  // Ordered "x strictly below y" for non-NaN inputs.
  function automatic logic sp_below(input logic [SP_W-1:0] x,
                                    input logic [SP_W-1:0] y);
    logic [SP_W-2:0] mx, my;
    mx = x[SP_W-2:0];
    my = y[SP_W-2:0];
    if (mx == '0 && my == '0)      return 1'b0;
    else if (x[SP_W-1] != y[SP_W-1]) return x[SP_W-1];
    else if (!x[SP_W-1])           return mx < my;
    else                           return mx > my;
  endfunction

  function automatic logic sp_same(input logic [SP_W-1:0] x,
                                   input logic [SP_W-1:0] y);
    return (x == y) || (x[SP_W-2:0] == '0 && y[SP_W-2:0] == '0);
  endfunction
endpackage

// File: rtl/fcmp_unbox.sv
module fcmp_unbox
  import fcmp_pkg::*;
(
  input  logic [REG_W-1:0] reg_val,
  output logic [SP_W-1:0]  sp_val,
  output logic             boxed_ok
);
  assign boxed_ok = &reg_val[REG_W-1:SP_W];
  assign sp_val   = boxed_ok ? reg_val[SP_W-1:0] : SP_CANON_NAN;
endmodule

// File: rtl/fcmp_core.sv
module fcmp_core
  import fcmp_pkg::*;
(
  input  logic [2:0]       op,
  input  logic [SP_W-1:0]  xa,
  input  logic [SP_W-1:0]  xb,
  input  sp_class_t        ca,
  input  sp_class_t        cb,
  output logic [REG_W-1:0] res,
  output logic             inv
);
  logic any_nan, any_snan, lt_ab, lt_ba, eq_ab;
  logic [SP_W-1:0] pick_min, pick_max;

  assign any_nan  = ca.nan  | cb.nan;
  assign any_snan = ca.snan | cb.snan;
  assign lt_ab    = sp_below(xa, xb);
  assign lt_ba    = sp_below(xb, xa);
  assign eq_ab    = sp_same(xa, xb);

  always_comb begin
    if (ca.nan && cb.nan)       pick_min = SP_CANON_NAN;
    else if (ca.nan)            pick_min = xb;
    else if (cb.nan)            pick_min = xa;
    else if (ca.zero && cb.zero) pick_min = xa[SP_W-1] ? xa : xb;
    else                        pick_min = lt_ba ? xb : xa;
  end

  always_comb begin
    if (ca.nan && cb.nan)       pick_max = SP_CANON_NAN;
    else if (ca.nan)            pick_max = xb;
    else if (cb.nan)            pick_max = xa;
    else if (ca.zero && cb.zero) pick_max = xb[SP_W-1] ? xa : xb;
    else                        pick_max = lt_ab ? xb : xa;
  end

  always_comb begin
    res = '0;
    inv = 1'b0;
    case (op)
      OP_EQ: begin res[0] = !any_nan && eq_ab;            inv = any_snan; end
      OP_LT: begin res[0] = !any_nan && lt_ab;            inv = any_nan;  end
      OP_LE: begin res[0] = !any_nan && (lt_ab || eq_ab); inv = any_nan;  end
      OP_MIN: begin res = {{BOX_W{1'b1}}, pick_min};      inv = any_snan; end
      OP_MAX: begin res = {{BOX_W{1'b1}}, pick_max};      inv = any_snan; end
      default: begin res = '0; inv = 1'b0; end
    endcase
  end
endmodule

// File: rtl/fcmp_minmax_unit.sv
module fcmp_minmax_unit
  import fcmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [2:0]       op,
  input  logic [63:0]      a,
  input  logic [63:0]      b,
  output logic [63:0]      result,
  output logic             invalid,
  output logic             valid_out
);
  logic [REG_W-1:0] opnd_raw [2];
  logic [SP_W-1:0]  opnd_sp  [2];
  logic             opnd_box [2];
  sp_class_t        opnd_cls [2];

  assign opnd_raw[0] = a;
  assign opnd_raw[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    fcmp_unbox u_unbox (
      .reg_val (opnd_raw[i]),
      .sp_val  (opnd_sp[i]),
      .boxed_ok(opnd_box[i])
    );
    assign opnd_cls[i] = sp_classify(opnd_sp[i]);
  end

  // Named events for the checker.
  logic a_boxed, b_boxed, a_nan, b_nan, a_snan, b_snan;
  assign a_boxed = opnd_box[0];
  assign b_boxed = opnd_box[1];
  assign a_nan   = opnd_cls[0].nan;
  assign b_nan   = opnd_cls[1].nan;
  assign a_snan  = opnd_cls[0].snan;
  assign b_snan  = opnd_cls[1].snan;

  logic [REG_W-1:0] core_res;
  logic             core_inv;

  fcmp_core u_core (
    .op (op),
    .xa (opnd_sp[0]),
    .xb (opnd_sp[1]),
    .ca (opnd_cls[0]),
    .cb (opnd_cls[1]),
    .res(core_res),
    .inv(core_inv)
  );

  if (REG_OUT) begin : g_reg
    logic [REG_W-1:0] res_q;
    logic             inv_q, vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        inv_q <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        res_q <= valid_in ? core_res : '0;
        inv_q <= valid_in & core_inv;
        vld_q <= valid_in;
      end
    end
    assign result    = res_q;
    assign invalid   = inv_q;
    assign valid_out = vld_q;
  end else begin : g_comb
    assign result    = valid_in ? core_res : '0;
    assign invalid   = valid_in & core_inv;
    assign valid_out = valid_in;
  end
endmodule

// File: rtl/fcmp_minmax_chk.sv
module fcmp_minmax_chk
  import fcmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_in,
  input logic [2:0]  op,
  input logic [63:0] result,
  input logic        invalid,
  input logic        valid_out,
  input logic        a_boxed,
  input logic        b_boxed,
  input logic        a_nan,
  input logic        b_nan,
  input logic        a_snan,
  input logic        b_snan
);
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> (result == '0 && !invalid));

  if (REG_OUT) begin : g_seq
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out == $past(valid_in));

    assert_cmp_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && $past(op) <= OP_LE) |-> (result[63:1] == '0));

    assert_box_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && ($past(op) == OP_MIN || $past(op) == OP_MAX))
        |-> (&result[63:32]));

    assert_ord_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && ($past(op) == OP_LT || $past(op) == OP_LE)
        && $past(a_nan || b_nan)) |-> (invalid && result == '0));

    assert_quiet_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && ($past(op) == OP_EQ || $past(op) == OP_MIN ||
        $past(op) == OP_MAX) && invalid) |-> $past(a_snan || b_snan));

    assert_unbox_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && !$past(a_boxed) && !$past(b_boxed) &&
        ($past(op) == OP_EQ || $past(op) == OP_MAX || $past(op) == OP_MIN))
        |-> !invalid);

    assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && $past(op) > OP_MAX) |-> (result == '0 && !invalid));
  end
endmodule

bind fcmp_minmax_unit fcmp_minmax_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
  .result(result), .invalid(invalid), .valid_out(valid_out),
  .a_boxed(a_boxed), .b_boxed(b_boxed), .a_nan(a_nan), .b_nan(b_nan),
  .a_snan(a_snan), .b_snan(b_snan)
);

// File: tb/tb_fcmp_minmax_unit.sv
module tb_fcmp_minmax_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [63:0] result;
  logic        invalid, valid_out;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] M1 = 32'hBF80_0000, M2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, MZ = 32'h8000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, MINF = 32'hFF80_0000;
  localparam logic [31:0] QN = 32'h7FC0_0001, SN = 32'h7F80_0001;
  localparam logic [31:0] PDN = 32'h0000_0001, MDN = 32'h8000_0001;
  localparam logic [63:0] CANON = 64'hFFFF_FFFF_7FC0_0000;
  localparam logic [63:0] UNB1 = 64'h0000_0000_3F80_0000;

  always #5 clk = ~clk;

  fcmp_minmax_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .a(a), .b(b),
    .result(result), .invalid(invalid), .valid_out(valid_out)
  );

  function automatic logic [63:0] bx(input logic [31:0] v);
    return {32'hFFFF_FFFF, v};
  endfunction

  task automatic chk(input string req, input logic [2:0] o,
                     input logic [63:0] xa, input logic [63:0] xb,
                     input logic [63:0] exp_res, input logic exp_inv);
    @(negedge clk);
    op = o; a = xa; b = xb; valid_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid_in = 1'b0;
    n_chk++;
    if (result !== exp_res || invalid !== exp_inv || valid_out !== 1'b1) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: got res=%h inv=%b vld=%b, expected res=%h inv=%b",
               req, o, xa, xb, result, invalid, valid_out, exp_res, exp_inv);
    end
  endtask

  task automatic t_reset;
    n_chk++;
    if (result !== '0 || invalid !== 1'b0 || valid_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: got res=%h inv=%b vld=%b, expected 0 0 0",
               result, invalid, valid_out);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    op = 3'd4; a = bx(SN); b = bx(P1); valid_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (result !== '0 || invalid !== 1'b0 || valid_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 idle: got res=%h inv=%b vld=%b, expected 0 0 0",
               result, invalid, valid_out);
    end
  endtask

  task automatic t_equal;
    chk("R2", 3'd0, bx(P1), bx(P1), 64'd1, 1'b0);
    chk("R2", 3'd0, bx(P1), bx(P2), 64'd0, 1'b0);
    chk("R2", 3'd0, bx(PZ), bx(MZ), 64'd1, 1'b0);
    chk("R2", 3'd0, bx(PINF), bx(PINF), 64'd1, 1'b0);
    chk("R2", 3'd0, bx(QN), bx(QN), 64'd0, 1'b0);
    chk("R2", 3'd0, bx(SN), bx(P1), 64'd0, 1'b1);
  endtask

  task automatic t_order;
    chk("R3", 3'd1, bx(M2), bx(M1), 64'd1, 1'b0);
    chk("R3", 3'd1, bx(M1), bx(M2), 64'd0, 1'b0);
    chk("R3", 3'd1, bx(P1), bx(P1), 64'd0, 1'b0);
    chk("R3", 3'd1, bx(MZ), bx(PZ), 64'd0, 1'b0);
    chk("R3", 3'd1, bx(PZ), bx(PDN), 64'd1, 1'b0);
    chk("R3", 3'd1, bx(PDN), bx(PZ), 64'd0, 1'b0);
    chk("R3", 3'd1, bx(MINF), bx(MDN), 64'd1, 1'b0);
    chk("R3", 3'd1, bx(QN), bx(P1), 64'd0, 1'b1);
    chk("R4", 3'd2, bx(P1), bx(P1), 64'd1, 1'b0);
    chk("R3", 3'd2, bx(MZ), bx(PZ), 64'd1, 1'b0);
    chk("R3", 3'd2, bx(P2), bx(P1), 64'd0, 1'b0);
    chk("R3", 3'd2, bx(P1), bx(SN), 64'd0, 1'b1);
  endtask

  task automatic t_unboxed;
    chk("R1", 3'd0, UNB1, bx(P1), 64'd0, 1'b0);
    chk("R1", 3'd1, UNB1, bx(P1), 64'd0, 1'b1);
    chk("R1", 3'd3, UNB1, bx(P2), bx(P2), 1'b0);
    chk("R1", 3'd4, UNB1, 64'h1234_5678_3F80_0000, CANON, 1'b0);
  endtask

  task automatic t_minmax;
    chk("R7", 3'd3, bx(P1), bx(P2), bx(P1), 1'b0);
    chk("R7", 3'd4, bx(P1), bx(P2), bx(P2), 1'b0);
    chk("R7", 3'd3, bx(M1), bx(M2), bx(M2), 1'b0);
    chk("R7", 3'd4, bx(MINF), bx(PDN), bx(PDN), 1'b0);
    chk("R5", 3'd3, bx(QN), bx(P2), bx(P2), 1'b0);
    chk("R5", 3'd4, bx(SN), bx(M1), bx(M1), 1'b1);
    chk("R5", 3'd3, bx(QN), bx(SN), CANON, 1'b1);
    chk("R5", 3'd4, bx(QN), bx(QN), CANON, 1'b0);
  endtask

  task automatic t_zeros;
    chk("R6", 3'd3, bx(PZ), bx(MZ), bx(MZ), 1'b0);
    chk("R6", 3'd3, bx(MZ), bx(PZ), bx(MZ), 1'b0);
    chk("R6", 3'd4, bx(PZ), bx(MZ), bx(PZ), 1'b0);
    chk("R6", 3'd4, bx(MZ), bx(PZ), bx(PZ), 1'b0);
    chk("R6", 3'd3, bx(PZ), bx(PZ), bx(PZ), 1'b0);
  endtask

  task automatic t_reserved;
    chk("R8", 3'd5, bx(SN), bx(P1), 64'd0, 1'b0);
    chk("R8", 3'd7, bx(P1), bx(P1), 64'd0, 1'b0);
  endtask

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_equal();
    t_order();
    t_unboxed();
    t_minmax();
    t_zeros();
    t_reserved();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule